// File: doc/BRIEF.md
# Ethernet Link Pulse Generator

This block produces the idle-line link pulses and the auto-negotiation pulse bursts that a 10/100 Ethernet PHY transmits. It has two modes. In plain link mode it requests one short pulse per period. In negotiation mode, each period begins with a burst. The burst carries a 16-bit code word: clock pulses sit at fixed spacing, and an optional data pulse sits midway between two clock pulses for each bit of the word.

The output is a one-bit pulse request to the analog line driver. A one-cycle strobe marks the end of each burst. All timing is given in reference-clock cycles through parameters. The defaults assume a 50 MHz clock:

| Parameter | Default | Meaning |
|---|---|---|
| PULSE_W | 5 | Pulse width, about 100 ns |
| NLP_PERIOD | 800000 | Link period, about 16 ms |
| CLK_SPACING | 6250 | Spacing between clock pulses, about 125 µs |
| DATA_OFS | 3125 | Data pulse offset after its clock pulse, about 62.5 µs |
| BURST_PERIOD | 800000 | Burst period, about 16 ms |

The legal settings require PULSE_W < DATA_OFS < CLK_SPACING and 16*CLK_SPACING + PULSE_W + 1 < BURST_PERIOD.

Cycle offsets below count from a period's start cycle. The first start cycle is the first enabled cycle, and later start cycles come one period after the previous one. A pulse scheduled at offset k is high during cycles k+1 through k+PULSE_W.

Top module: `link_pulse_gen`

## Requirements
- R1: Every pulse is high for exactly PULSE_W consecutive cycles and starts the cycle after its scheduled offset.
- R2: With mode_i = 0 (plain link mode), one pulse is scheduled at offset 0 of each period. The period is NLP_PERIOD cycles, and the first period begins in the first cycle in which en_i is high.
- R3: With mode_i = 1 (negotiation mode), a burst holds 17 clock pulses at offsets j*CLK_SPACING for j = 0..16. With an all-zero code word, this gives 17 pulses per burst.
- R4: The data pulse for bit j (bit 0 first, j = 0..15) is scheduled at offset j*CLK_SPACING + DATA_OFS when bit j is 1 and is absent when bit j is 0. An all-ones word therefore gives 33 pulses.
- R5: In negotiation mode, bursts repeat every BURST_PERIOD cycles.
- R6: code_i is sampled in the start cycle of a burst. A change during the burst leaves that burst unchanged and applies from the next burst.
- R7: mode_i is sampled in each period's start cycle. A change during a period takes effect at the next period start, and the sampled mode selects the length of that period.
- R8: done_o is high for exactly one cycle, at offset 16*CLK_SPACING + PULSE_W + 1 of each burst. This is the cycle right after the last clock pulse ends. done_o never rises in plain link mode.
- R9: A cycle with en_i low forces pulse_o and done_o low from the next cycle. Timing restarts from offset 0 when en_i returns.
- R10: While rst_ni is low, pulse_o and done_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Generator enable |
| mode_i | input | 1 | 0 = plain link pulses, 1 = negotiation bursts |
| code_i | input | CODE_W | Code word sent in each burst, bit 0 first |
| pulse_o | output | 1 | Pulse request to the line driver |
| done_o | output | 1 | One-cycle end-of-burst strobe |

## Verification
The bench builds the block with PULSE_W = 2, NLP_PERIOD = 40, CLK_SPACING = 12, DATA_OFS = 6 and BURST_PERIOD = 260. With these values a whole burst with all its data slots fits in a few hundred cycles. Several bursts, mode changes across period boundaries, and code changes in mid-burst therefore fit in a short run. Under the same scaling, the pulse-width, slot-offset and end-of-burst strobe timing keep the same relations to one another as at the real-time defaults.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef enum logic {
    LPM_LINK    = 1'b0,
    LPM_AUTONEG = 1'b1
  } lp_mode_e;
endpackage

// File: rtl/lp_period_timer.sv
module lp_period_timer
  import lp_pkg::*;
#(
  parameter int unsigned NLP_PERIOD   = 800000,
  parameter int unsigned BURST_PERIOD = 800000,
  localparam int unsigned MAX_PERIOD  = (NLP_PERIOD > BURST_PERIOD) ? NLP_PERIOD : BURST_PERIOD,
  localparam int unsigned CNT_W       = $clog2(MAX_PERIOD)
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  lp_mode_e mode_i,
  output logic     start_o,
  output lp_mode_e mode_o
);

  logic [CNT_W-1:0] cnt_q;
  lp_mode_e         mode_q;
  logic [CNT_W-1:0] last_cnt;

  assign start_o  = en_i && (cnt_q == '0);
  // mode is taken live in the start cycle, held for the rest of the period
  assign mode_o   = start_o ? mode_i : mode_q;
  assign last_cnt = (mode_o == LPM_AUTONEG) ? CNT_W'(BURST_PERIOD - 1) : CNT_W'(NLP_PERIOD - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= LPM_LINK;
    end else if (!en_i) begin
      cnt_q  <= '0;
    end else begin
      cnt_q  <= (cnt_q == last_cnt) ? '0 : cnt_q + 1'b1;
      mode_q <= mode_o;
    end
  end

endmodule

// File: rtl/lp_burst_seq.sv
module lp_burst_seq #(
  parameter int unsigned CODE_W      = 16,
  parameter int unsigned CLK_SPACING = 6250,
  parameter int unsigned DATA_OFS    = 3125,
  localparam int unsigned IDX_W      = $clog2(CODE_W + 1),
  localparam int unsigned SUB_W      = $clog2(CLK_SPACING)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              clk_fire_o,
  output logic              data_fire_o,
  output logic              last_fire_o
);

  logic              active_q;
  logic [SUB_W-1:0]  sub_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CODE_W-1:0] code_q;
  logic              slot_edge;

  assign slot_edge   = active_q && (sub_q == '0);
  // slot 0 clock pulse comes straight from the start cycle
  assign clk_fire_o  = start_i || slot_edge;
  assign last_fire_o = slot_edge && (idx_q == IDX_W'(CODE_W));
  assign data_fire_o = active_q && (sub_q == SUB_W'(DATA_OFS)) &&
                       (idx_q < IDX_W'(CODE_W)) && code_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sub_q    <= '0;
      idx_q    <= '0;
      code_q   <= '0;
    end else if (!en_i) begin
      active_q <= 1'b0;
      sub_q    <= '0;
      idx_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      sub_q    <= SUB_W'(1);
      idx_q    <= '0;
      code_q   <= code_i;
    end else if (active_q) begin
      if (last_fire_o) begin
        active_q <= 1'b0;
      end else if (sub_q == SUB_W'(CLK_SPACING - 1)) begin
        sub_q  <= '0;
        idx_q  <= idx_q + 1'b1;
        code_q <= code_q >> 1;
      end else begin
        sub_q  <= sub_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lp_pulse_shaper.sv
module lp_pulse_shaper #(
  parameter int unsigned PULSE_W = 5,
  localparam int unsigned WC_W   = $clog2(PULSE_W + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic fire_i,
  input  logic last_i,
  output logic pulse_o,
  output logic done_o
);

  logic [WC_W-1:0] wc_q;
  logic            pend_q;
  logic            done_q;
  logic            tail;

  assign pulse_o = (wc_q != '0);
  assign done_o  = done_q;
  // final cycle of the last clock pulse of a burst
  assign tail    = pend_q && (wc_q == WC_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wc_q   <= '0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else if (!en_i) begin
      wc_q   <= '0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (fire_i)            wc_q <= WC_W'(PULSE_W);
      else if (wc_q != '0)   wc_q <= wc_q - 1'b1;
      if (last_i)            pend_q <= 1'b1;
      else if (tail)         pend_q <= 1'b0;
      done_q <= tail;
    end
  end

endmodule

// File: rtl/link_pulse_gen.sv
module link_pulse_gen
  import lp_pkg::*;
#(
  parameter int unsigned PULSE_W      = 5,
  parameter int unsigned NLP_PERIOD   = 800000,
  parameter int unsigned BURST_PERIOD = 800000,
  parameter int unsigned CLK_SPACING  = 6250,
  parameter int unsigned DATA_OFS     = 3125,
  parameter int unsigned CODE_W       = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              mode_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              pulse_o,
  output logic              done_o
);

  logic     start;
  lp_mode_e mode_eff;
  logic     link_fire;
  logic     burst_start;
  logic     clk_fire;
  logic     data_fire;
  logic     last_fire;

  lp_period_timer #(
    .NLP_PERIOD  (NLP_PERIOD),
    .BURST_PERIOD(BURST_PERIOD)
  ) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .mode_i (lp_mode_e'(mode_i)),
    .start_o(start),
    .mode_o (mode_eff)
  );

  assign link_fire   = start && (mode_eff == LPM_LINK);
  assign burst_start = start && (mode_eff == LPM_AUTONEG);

  lp_burst_seq #(
    .CODE_W     (CODE_W),
    .CLK_SPACING(CLK_SPACING),
    .DATA_OFS   (DATA_OFS)
  ) i_burst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .start_i    (burst_start),
    .code_i     (code_i),
    .clk_fire_o (clk_fire),
    .data_fire_o(data_fire),
    .last_fire_o(last_fire)
  );

  lp_pulse_shaper #(
    .PULSE_W(PULSE_W)
  ) i_shaper (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .fire_i (link_fire || clk_fire || data_fire),
    .last_i (last_fire),
    .pulse_o(pulse_o),
    .done_o (done_o)
  );

endmodule

// File: rtl/lp_chk.sv
module lp_chk #(
  parameter int unsigned PULSE_W = 5
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic pulse_o,
  input logic done_o
);

  int unsigned hi_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  hi_run <= 0;
    else if (!pulse_o)            hi_run <= 0;
    else if (hi_run <= PULSE_W)   hi_run <= hi_run + 1;
  end

  // R1
  pulse_not_long_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> hi_run < PULSE_W);

  // R1
  pulse_full_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_o && $past(pulse_o) && $past(en_i)) |-> ($past(hi_run) == PULSE_W - 1));

  // R8
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  done_after_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!pulse_o && $past(pulse_o)));

  // R9
  idle_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!pulse_o && !done_o));

endmodule

bind link_pulse_gen lp_chk #(.PULSE_W(PULSE_W)) i_lp_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .pulse_o(pulse_o),
  .done_o (done_o)
);

// File: tb/test_link_pulse_gen.sv
module test_link_pulse_gen;
  localparam int W   = 2;
  localparam int NLP = 40;
  localparam int BP  = 260;
  localparam int S   = 12;
  localparam int D   = 6;

  logic        clk = 0;
  logic        rst_ni = 0;
  logic        en = 0;
  logic        mode = 0;
  logic [15:0] code = '0;
  logic        pulse, done;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string cur_req = "R10";
  bit chk_on = 0;

  always #2 clk = ~clk;

  link_pulse_gen #(
    .PULSE_W(W), .NLP_PERIOD(NLP), .BURST_PERIOD(BP),
    .CLK_SPACING(S), .DATA_OFS(D), .CODE_W(16)
  ) i_link_pulse_gen (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .mode_i(mode),
    .code_i(code), .pulse_o(pulse), .done_o(done)
  );

  // behavioural reference, state after each edge
  int          m_pc, m_left;
  bit          m_done, m_mode;
  logic [15:0] m_code;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pc = 0; m_left = 0; m_done = 0; m_mode = 0; m_code = '0;
    end else if (!en) begin
      m_pc = 0; m_left = 0; m_done = 0;
    end else begin
      bit st, md, fire;
      logic [15:0] cw;
      int slot, off, per;
      st = (m_pc == 0);
      md = st ? mode : m_mode;
      cw = st ? code : m_code;
      fire = 0;
      if (!md) fire = st;
      else begin
        slot = m_pc / S;
        off  = m_pc % S;
        if (off == 0 && slot <= 16) fire = 1;
        if (off == D && slot < 16 && cw[slot]) fire = 1;
      end
      m_done = md && (m_pc == 16*S + W);
      if (fire) m_left = W;
      else if (m_left > 0) m_left = m_left - 1;
      per = md ? BP : NLP;
      m_pc = (m_pc == per - 1) ? 0 : m_pc + 1;
      m_mode = md;
      m_code = cw;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  bit prev_p = 0;
  int rises = 0;
  always @(negedge clk) begin
    cycles++;
    if (chk_on) begin
      chk(cur_req, "pulse_o", int'(pulse), int'(m_left > 0));
      chk("R8", "done_o", int'(done), int'(m_done));
    end
    if (pulse && !prev_p) rises++;
    prev_p = pulse;
  end

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    wait (cycles > 150000);
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    finish_up();
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart();
    en = 0;
    run(3);
  endtask

  initial begin
    run(3);
    // R10 reset state
    chk("R10", "pulse_o in reset", int'(pulse), 0);
    chk("R10", "done_o in reset", int'(done), 0);
    rst_ni = 1;
    chk_on = 1;
    cur_req = "R9";
    run(20);

    cur_req = "R1"; mode = 0; en = 1;
    run(40);
    cur_req = "R2";
    run(100);

    cur_req = "R9"; restart();
    cur_req = "R3"; mode = 1; code = 16'h0000; rises = 0; en = 1;
    run(BP);
    chk("R3", "pulses in zero-code burst", rises, 17);

    restart();
    cur_req = "R4"; code = 16'hFFFF; rises = 0; en = 1;
    run(BP);
    chk("R4", "pulses in all-ones burst", rises, 33);

    restart();
    cur_req = "R5"; code = 16'hA5C3; en = 1;
    run(3*BP);

    restart();
    cur_req = "R6"; code = 16'h1234; rises = 0; en = 1;
    run(50);
    code = 16'hFFFF;
    run(BP - 50);
    chk("R6", "pulses in burst with mid-burst code change", rises, 22);
    run(BP);

    restart();
    cur_req = "R7"; mode = 0; en = 1;
    run(10);
    mode = 1; code = 16'h00F0;
    run(NLP + BP + 20);
    mode = 0;
    run(BP);

    cur_req = "R9"; restart();
    mode = 1; code = 16'h5555; en = 1;
    run(100);
    en = 0;
    run(5);
    chk("R9", "pulse_o after disable", int'(pulse), 0);
    en = 1;
    run(BP + 50);

    finish_up();
  end

endmodule